// File: doc/BRIEF.md
# Power State and Clock Gating Controller

This block decides which of three power modes a processor subsystem is in: running, dozing or sleeping. From that mode it drives the clock-enable and reset line of each on-chip peripheral, the processor clock enable, the PLL enable, and the SDRAM controller's enable and self-refresh request. Software enters doze by writing to one write-only bus address; any data is accepted and no data bus is needed. A separate request line enters sleep. An interrupt ends either mode.

Two reset inputs are handled. The power-on reset input must be held low for a programmable number of reference-clock cycles before the block lets the system out of reset; a shorter pulse leaves it held. The user reset input resets everything except the real-time clock, but it leaves the SDRAM lines alone so memory contents survive. On wake from sleep, the PLL is started first, SDRAM self-refresh is exited second, and the processor clock returns last, with each phase lasting a parameter-set number of cycles.

Top module: `pwr_state_ctrl`

## Requirements
- R1: A bus write whose address equals HALT_ADDR, made in running mode with no interrupt pending, moves the block to doze one clock later. Only the processor clock enable falls. A write to any other address has no effect.
- R2: A write to HALT_ADDR while the interrupt input is high is ignored, and the block stays in running mode.
- R3: In doze, a high interrupt input returns the block to running mode one clock later. A sleep request made in doze is ignored.
- R4: Peripheral vector bit positions: 0 UART, 1 LCD FIFO, 2 LCD, 3 ADC, 4 SSI, 5 DAI, 6 codec, 7 timers, 8 DC-to-DC, 9 RTC, 10 LED flasher, 11 interrupt controller. In running and doze, all enables are 1, all resets are 0, the PLL is enabled, SDRAM is enabled and not in self-refresh. The processor clock enable is 1 only in running mode.
- R5: A sleep request in running mode with no interrupt pending enters sleep one clock later. In sleep, the processor clock and PLL are off, SDRAM is enabled with self-refresh requested, and every peripheral enable except bits 9, 10 and 11 is 0.
- R6: In sleep, the RTC, LED flasher and interrupt controller stay enabled, and the LCD FIFO (bit 1) is held in reset.
- R7: An interrupt in sleep starts the wake sequence. For WAKE_PLL_CYC cycles the PLL is on and self-refresh is still requested. For WAKE_MEM_CYC cycles after that, the PLL is on and self-refresh is off. Then running mode resumes. Throughout, the processor clock enable is never 1 unless the PLL is on and self-refresh is off.
- R8: Two clocks after the power-on reset input goes low, all peripherals except the RTC are held in reset with enables 0. The RTC stays enabled and out of reset. The SDRAM enable, self-refresh, PLL and processor clock are all 0.
- R9: Two clocks after the user reset input goes low, the peripheral, PLL and processor clock outputs take the power-on reset values, while the SDRAM enable and self-refresh keep their previous values. Running mode resumes two clocks after it rises.
- R10: Power-on reset is released only after its input has been low for at least POR_MIN_CYC consecutive clocks. Running mode appears two clocks after the input rises. A shorter low pulse leaves the block in reset.
- R11: The mode output reads 00 in running mode and during reset, 01 in doze, and 10 in sleep and during wake. It never reads 11.
- R12: All outputs are registered and change only on the clock edge that changes the internal state.
- R13: A sleep request made while the interrupt input is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n_i | input | 1 | Power-on reset, active low |
| usr_rst_n_i | input | 1 | User reset, active low |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_addr_i | input | ADDR_W | Bus write address |
| irq_pending_i | input | 1 | Any interrupt active |
| stby_req_i | input | 1 | Request to enter sleep |
| cpu_clk_en_o | output | 1 | Processor clock enable |
| pll_en_o | output | 1 | PLL enable |
| sdram_en_o | output | 1 | SDRAM controller enable |
| sdram_selfref_o | output | 1 | SDRAM self-refresh request |
| periph_en_o | output | 12 | Peripheral clock enables (bit map in R4) |
| periph_rst_o | output | 12 | Peripheral resets, active high |
| mode_o | output | 2 | Current mode (encoding in R11) |

## Verification
The hardest case to reach is a user reset arriving while SDRAM is in self-refresh, because the SDRAM lines must then freeze at the sleep values rather than at the running ones. The stimulus first enters sleep through the request line, then pulls the user reset low before any interrupt, and checks that the self-refresh request stays 1 while everything else resets. A second hard case is a power-on pulse shorter than the minimum. The stimulus gives one short low pulse, confirms the block stays in reset several cycles after the input rises, and then gives a full-length pulse to recover.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int NPERIPH = 12;
  localparam int P_UART = 0, P_LCDFIFO = 1, P_LCD = 2, P_ADC = 3, P_SSI = 4, P_DAI = 5;
  localparam int P_CODEC = 6, P_TIMER = 7, P_DCDC = 8, P_RTC = 9, P_LED = 10, P_INTC = 11;

  localparam logic [NPERIPH-1:0] KEEP_MASK = NPERIPH'((1 << P_RTC) | (1 << P_LED) | (1 << P_INTC));
  localparam logic [NPERIPH-1:0] FIFO_MASK = NPERIPH'(1 << P_LCDFIFO);
  localparam logic [NPERIPH-1:0] RTC_MASK  = NPERIPH'(1 << P_RTC);

  localparam logic [1:0] MODE_RUN = 2'b00, MODE_DOZE = 2'b01, MODE_SLEEP = 2'b10;

  typedef enum logic [2:0] {
    PS_RUN = 3'd0, PS_DOZE = 3'd1, PS_SLEEP = 3'd2, PS_WAKE_PLL = 3'd3, PS_WAKE_MEM = 3'd4
  } pstate_e;

  typedef struct packed {
    logic               cpu_en;
    logic               pll_en;
    logic               selfref;
    logic               sdram_en;
    logic [NPERIPH-1:0] en;
    logic [NPERIPH-1:0] rst;
  } pout_t;

  localparam pout_t PO_POR = '{cpu_en: 1'b0, pll_en: 1'b0, selfref: 1'b0, sdram_en: 1'b0,
                               en: RTC_MASK, rst: ~RTC_MASK};

  function automatic pout_t table_for(pstate_e s);
    pout_t o;
    o = PO_POR;
    o.sdram_en = 1'b1;
    if (s == PS_RUN || s == PS_DOZE) begin
      o.cpu_en  = (s == PS_RUN);
      o.pll_en  = 1'b1;
      o.selfref = 1'b0;
      o.en      = '1;
      o.rst     = '0;
    end else begin
      o.cpu_en  = 1'b0;
      o.pll_en  = (s == PS_WAKE_PLL) || (s == PS_WAKE_MEM);
      o.selfref = (s != PS_WAKE_MEM);
      o.en      = KEEP_MASK;
      o.rst     = FIFO_MASK;
    end
    return o;
  endfunction

  function automatic logic [1:0] mode_of(pstate_e s);
    case (s)
      PS_RUN:  return MODE_RUN;
      PS_DOZE: return MODE_DOZE;
      default: return MODE_SLEEP;
    endcase
  endfunction
endpackage

// File: rtl/pwr_por_filter.sv
module pwr_por_filter #(
  parameter int POR_MIN_CYC = 20000
) (
  input  logic clk,
  input  logic por_n_i,
  input  logic usr_rst_n_i,
  output logic por_rst_o,
  output logic usr_rst_o
);
  localparam int CW = $clog2(POR_MIN_CYC + 1);
  localparam logic [CW-1:0] LOW_MAX = CW'(POR_MIN_CYC);

  logic [CW-1:0] low_cnt  = '0;
  logic          released = 1'b0;
  logic          urst_q   = 1'b0;

  // A low pulse counts up to LOW_MAX; release only if the full count was reached.
  always_ff @(posedge clk) begin
    if (!por_n_i) begin
      released <= 1'b0;
      if (low_cnt != LOW_MAX) low_cnt <= low_cnt + CW'(1);
    end else begin
      if (low_cnt == LOW_MAX) released <= 1'b1;
      low_cnt <= '0;
    end
    urst_q <= !usr_rst_n_i;
  end

  assign por_rst_o = !released;
  assign usr_rst_o = urst_q;
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_pkg::*;
#(
  parameter int              ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] HALT_ADDR  = 16'h0800,
  parameter int              WAKE_PLL_CYC = 64,
  parameter int              WAKE_MEM_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              irq_i,
  input  logic              stby_req_i,
  output pstate_e           state_d_o
);
  localparam int WMAX = (WAKE_PLL_CYC > WAKE_MEM_CYC) ? WAKE_PLL_CYC : WAKE_MEM_CYC;
  localparam int WCW  = (WMAX > 1) ? $clog2(WMAX + 1) : 1;
  localparam logic [WCW-1:0] PLL_LAST = WCW'(WAKE_PLL_CYC - 1);
  localparam logic [WCW-1:0] MEM_LAST = WCW'(WAKE_MEM_CYC - 1);

  pstate_e        state_q = PS_RUN;
  pstate_e        state_d;
  logic [WCW-1:0] cnt_q = '0;
  logic [WCW-1:0] cnt_d;
  logic           halt_hit;

  assign halt_hit = bus_wr_i && (bus_addr_i == HALT_ADDR);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      PS_RUN: begin
        if (!irq_i) begin
          if (halt_hit)        state_d = PS_DOZE;
          else if (stby_req_i) state_d = PS_SLEEP;
        end
      end
      PS_DOZE:  if (irq_i) state_d = PS_RUN;
      PS_SLEEP: if (irq_i) begin state_d = PS_WAKE_PLL; cnt_d = '0; end
      PS_WAKE_PLL: begin
        if (cnt_q == PLL_LAST) begin state_d = PS_WAKE_MEM; cnt_d = '0; end
        else cnt_d = cnt_q + WCW'(1);
      end
      PS_WAKE_MEM: begin
        if (cnt_q == MEM_LAST) begin state_d = PS_RUN; cnt_d = '0; end
        else cnt_d = cnt_q + WCW'(1);
      end
      default: state_d = PS_RUN;
    endcase
    if (rst_i) begin
      state_d = PS_RUN;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk) begin
    state_q <= state_d;
    cnt_q   <= cnt_d;
  end

  assign state_d_o = state_d;
endmodule

// File: rtl/pwr_out_reg.sv
module pwr_out_reg
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       por_rst_i,
  input  logic       urst_i,
  input  pstate_e    state_d_i,
  output pout_t      out_o,
  output logic [1:0] mode_o
);
  pout_t      out_q  = PO_POR;
  logic [1:0] mode_q = MODE_RUN;
  pout_t      urst_val;

  always_comb begin
    urst_val          = PO_POR;
    urst_val.selfref  = out_q.selfref;
    urst_val.sdram_en = out_q.sdram_en;
  end

  // Outputs are registered from the next state, so they move on the same edge as the state.
  always_ff @(posedge clk) begin
    if (por_rst_i) begin
      out_q  <= PO_POR;
      mode_q <= MODE_RUN;
    end else if (urst_i) begin
      out_q  <= urst_val;
      mode_q <= MODE_RUN;
    end else begin
      out_q  <= table_for(state_d_i);
      mode_q <= mode_of(state_d_i);
    end
  end

  assign out_o  = out_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int                ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] HALT_ADDR    = 16'h0800,
  parameter int                POR_MIN_CYC  = 20000,
  parameter int                WAKE_PLL_CYC = 64,
  parameter int                WAKE_MEM_CYC = 16
) (
  input  logic               clk,
  input  logic               por_n_i,
  input  logic               usr_rst_n_i,
  input  logic               bus_wr_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               irq_pending_i,
  input  logic               stby_req_i,
  output logic               cpu_clk_en_o,
  output logic               pll_en_o,
  output logic               sdram_en_o,
  output logic               sdram_selfref_o,
  output logic [NPERIPH-1:0] periph_en_o,
  output logic [NPERIPH-1:0] periph_rst_o,
  output logic [1:0]         mode_o
);
  logic    por_rst;
  logic    usr_rst;
  logic    rst_any;
  pstate_e state_d;
  pout_t   outs;

  pwr_por_filter #(.POR_MIN_CYC(POR_MIN_CYC)) u_por (
    .clk(clk), .por_n_i(por_n_i), .usr_rst_n_i(usr_rst_n_i),
    .por_rst_o(por_rst), .usr_rst_o(usr_rst)
  );

  assign rst_any = por_rst | usr_rst;

  pwr_state_fsm #(
    .ADDR_W(ADDR_W), .HALT_ADDR(HALT_ADDR),
    .WAKE_PLL_CYC(WAKE_PLL_CYC), .WAKE_MEM_CYC(WAKE_MEM_CYC)
  ) u_fsm (
    .clk(clk), .rst_i(rst_any), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .irq_i(irq_pending_i), .stby_req_i(stby_req_i), .state_d_o(state_d)
  );

  pwr_out_reg u_out (
    .clk(clk), .por_rst_i(por_rst), .urst_i(usr_rst), .state_d_i(state_d),
    .out_o(outs), .mode_o(mode_o)
  );

  assign cpu_clk_en_o    = outs.cpu_en;
  assign pll_en_o        = outs.pll_en;
  assign sdram_en_o      = outs.sdram_en;
  assign sdram_selfref_o = outs.selfref;
  assign periph_en_o     = outs.en;
  assign periph_rst_o    = outs.rst;
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk
  import pwr_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] HALT_ADDR = 16'h0800
) (
  input logic               clk,
  input logic               rst_any,
  input logic               por_rst,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               irq,
  input logic               cpu_clk_en,
  input logic               pll_en,
  input logic               sdram_en,
  input logic               selfref,
  input logic [NPERIPH-1:0] periph_en,
  input logic [NPERIPH-1:0] periph_rst,
  input logic [1:0]         mode
);
  assert_halt_masked_R2: assert property (@(posedge clk) disable iff (rst_any)
    (mode == MODE_RUN && bus_wr && bus_addr == HALT_ADDR && irq) |=> (mode == MODE_RUN));

  assert_doze_wake_R3: assert property (@(posedge clk) disable iff (rst_any)
    (mode == MODE_DOZE && irq) |=> (mode == MODE_RUN && cpu_clk_en));

  assert_cpu_only_run_R4: assert property (@(posedge clk) disable iff (rst_any)
    cpu_clk_en |-> (mode == MODE_RUN));

  assert_sleep_keep_R6: assert property (@(posedge clk) disable iff (rst_any)
    (mode == MODE_SLEEP) |-> (periph_en[P_RTC] && periph_en[P_LED] && periph_en[P_INTC]
                              && periph_rst[P_LCDFIFO] && !cpu_clk_en));

  assert_cpu_after_pll_R7: assert property (@(posedge clk) disable iff (rst_any)
    cpu_clk_en |-> (pll_en && !selfref));

  assert_por_values_R8: assert property (@(posedge clk)
    por_rst |=> (!pll_en && !sdram_en && !cpu_clk_en && periph_en[P_RTC] && !periph_rst[P_RTC]));

  assert_mode_legal_R11: assert property (@(posedge clk) disable iff (rst_any)
    mode != 2'b11);
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk #(.ADDR_W(ADDR_W), .HALT_ADDR(HALT_ADDR)) u_chk (
  .clk(clk), .rst_any(rst_any), .por_rst(por_rst), .bus_wr(bus_wr_i), .bus_addr(bus_addr_i),
  .irq(irq_pending_i), .cpu_clk_en(cpu_clk_en_o), .pll_en(pll_en_o), .sdram_en(sdram_en_o),
  .selfref(sdram_selfref_o), .periph_en(periph_en_o), .periph_rst(periph_rst_o), .mode(mode_o)
);

// File: tb/tb_pwr_state_ctrl.sv
`timescale 1ns/100ps
module tb_pwr_state_ctrl;
  localparam int ADDR_W = 16;
  localparam logic [ADDR_W-1:0] HALT = 16'h0800;
  localparam int PLLC = 4, MEMC = 3, PORC = 40;
  localparam int K_RUN = 0, K_DOZE = 1, K_SLEEP = 2, K_WPLL = 3, K_WMEM = 4, K_POR = 5, K_URST = 6;

  logic clk = 1'b0;
  logic por_n = 1'b0, usr_rst_n = 1'b1, bus_wr = 1'b0, irq = 1'b0, stby = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic cpu_en, pll_en, sd_en, sr;
  logic [11:0] p_en, p_rst;
  logic [1:0] mode;

  always #2.5 clk = ~clk;

  pwr_state_ctrl #(.ADDR_W(ADDR_W), .HALT_ADDR(HALT), .POR_MIN_CYC(PORC),
                   .WAKE_PLL_CYC(PLLC), .WAKE_MEM_CYC(MEMC)) dut (
    .clk(clk), .por_n_i(por_n), .usr_rst_n_i(usr_rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .irq_pending_i(irq), .stby_req_i(stby), .cpu_clk_en_o(cpu_en), .pll_en_o(pll_en),
    .sdram_en_o(sd_en), .sdram_selfref_o(sr), .periph_en_o(p_en), .periph_rst_o(p_rst), .mode_o(mode)
  );

  typedef struct { int due; string req; logic [29:0] v; } exp_t;
  exp_t q[$];
  int cyc = 0, tests = 0, fails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Expected output vector {mode, cpu, pll, selfref, sdram_en, en[11:0], rst[11:0]} from R4-R9.
  function automatic logic [29:0] model(int kind, bit h_sr, bit h_sd);
    case (kind)
      K_RUN:   return {2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 12'hFFF, 12'h000};
      K_DOZE:  return {2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 12'hFFF, 12'h000};
      K_SLEEP: return {2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 12'hE00, 12'h002};
      K_WPLL:  return {2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 12'hE00, 12'h002};
      K_WMEM:  return {2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 12'hE00, 12'h002};
      K_POR:   return {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 12'h200, 12'hDFF};
      default: return {2'b00, 1'b0, 1'b0, h_sr, h_sd, 12'h200, 12'hDFF};
    endcase
  endfunction

  task automatic push(string req, int k, int kind, bit h_sr = 1'b0, bit h_sd = 1'b0);
    exp_t e;
    e.due = cyc + k; e.req = req; e.v = model(kind, h_sr, h_sd);
    q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_addr(logic [ADDR_W-1:0] a);
    bus_wr = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Monitor: pops expectations once their cycle has come and compares against the ports.
  initial begin
    forever begin
      @(negedge clk); #1;
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        logic [29:0] act;
        e = q.pop_front();
        act = {mode, cpu_en, pll_en, sr, sd_en, p_en, p_rst};
        tests++;
        if (act !== e.v) begin
          fails++;
          $display("FAIL %s at cycle %0d: actual %h expected %h", e.req, cyc, act, e.v);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    push("R8", 0, K_POR);                          // reset state
    step(45);
    por_n = 1'b1;
    push("R10", 1, K_POR); push("R10", 2, K_RUN);
    step(3);
    push("R1", 1, K_RUN); write_addr(16'h0804);    // other address ignored
    push("R1", 1, K_DOZE); write_addr(HALT);
    step(2);
    stby = 1'b1; push("R3", 1, K_DOZE); step(1); stby = 1'b0;
    irq = 1'b1; push("R3", 1, K_RUN); step(1);
    push("R2", 1, K_RUN); write_addr(HALT);        // masked by pending interrupt
    stby = 1'b1; push("R13", 1, K_RUN); step(1); stby = 1'b0;
    irq = 1'b0; step(1);
    stby = 1'b1; push("R5", 1, K_SLEEP); step(1); stby = 1'b0;
    step(2); push("R6", 0, K_SLEEP);
    irq = 1'b1;
    push("R7", 1, K_WPLL); push("R7", PLLC, K_WPLL); push("R7", PLLC + 1, K_WMEM);
    push("R7", PLLC + MEMC, K_WMEM); push("R7", PLLC + MEMC + 1, K_RUN);
    step(1); irq = 1'b0; step(PLLC + MEMC + 2);
    usr_rst_n = 1'b0;
    push("R12", 1, K_RUN); push("R9", 2, K_URST, 1'b0, 1'b1);
    step(4); usr_rst_n = 1'b1;
    push("R9", 1, K_URST, 1'b0, 1'b1); push("R9", 2, K_RUN);
    step(3);
    stby = 1'b1; step(1); stby = 1'b0; step(1);
    usr_rst_n = 1'b0; push("R9", 2, K_URST, 1'b1, 1'b1);   // SDRAM held in self-refresh
    step(4); usr_rst_n = 1'b1; push("R9", 2, K_RUN);
    step(3);
    por_n = 1'b0; push("R8", 2, K_POR);
    step(10); por_n = 1'b1;                         // too short
    push("R10", 1, K_POR); push("R10", 5, K_POR);
    step(6);
    por_n = 1'b0; step(45); por_n = 1'b1;
    push("R10", 2, K_RUN); push("R11", 3, K_RUN);
    step(5);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule